// File: doc/BRIEF.md
# Sliced Wide Unsigned Adder

This block adds two wide unsigned operands one slice at a time. The least significant slice goes first, and the whole addition is done on one narrow adder. Each slice is added on a datapath that is wider than the slice. One operand slice is extended upward with zeros and the other with ones. The carry into the next slice is then read as the inverted top bit of that widened sum. No separate carry-out tap of the adder is used. With the default parameters the operands are 256 bits and the slices are 32 bits wide, so the padded adder is 48 bits and one addition takes eight slice steps.

A caller presents both operands, pulses `start` for one cycle and keeps the operands steady until `done` pulses. The result slices are written into the sum register as they are produced, and each slice is final once it is written. The carry out of the top slice does not change the sum. It is reported separately on `carry_out` so that full-width overflow can be checked.

Top module: `chunked_wide_adder`

## Requirements
- R1: A `start` pulse seen while idle begins an addition. Slice k (bits k*CHUNK_W upward) is written at the (k+1)-th rising edge after the edge that accepted `start`. `done` is high during the cycle that follows the edge writing the last slice.
- R2: When `done` is high, `sum` equals (op_a + op_b) modulo 2^TOTAL_W.
- R3: When `done` is high, `carry_out` equals bit TOTAL_W of the full-precision sum op_a + op_b.
- R4: The first slice takes a carry-in of 0. The carry into each later slice is the inverse of the top bit of the previous slice's padded sum. The padded sum adds the zero-extended slice of op_a, the one-extended slice of op_b and the carry-in at bit 0. A carry therefore ripples correctly across every slice boundary.
- R5: A `start` pulse received while an addition is in progress is ignored. The slice sequence, the `done` timing and the result are unchanged.
- R6: While `rst_n` is low, and at its release, `done` is 0, `carry_out` is 0, `sum` is all zeros and the block is idle.
- R7: `done` is exactly one cycle wide and never rises without a preceding accepted `start`.
- R8: The slice width, the padding width and the operand width are parameters. Any configuration where CHUNK_W divides TOTAL_W and PAD_W is at least 1 gives the same exact results as R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| start | input | 1 | One-cycle request to begin an addition; ignored while busy |
| op_a | input | TOTAL_W | First operand, held stable during the addition |
| op_b | input | TOTAL_W | Second operand, held stable during the addition |
| sum | output | TOTAL_W | Sum modulo 2^TOTAL_W, valid when `done` is high |
| carry_out | output | 1 | Carry out of the most significant slice, valid when `done` is high |
| done | output | 1 | One-cycle pulse marking a completed addition |

## Verification
A reduced instance (6-bit operands in 2-bit slices with 2-bit padding) is swept over every operand pair. This shows that the padding trick gives the right carry for every slice value and every carry-in combination. The full-width instance is driven with several patterns. Zero plus zero shows that no carry is produced from nothing. All ones plus one makes a carry ripple through all eight slices. All ones plus all ones sets every carry and leaves all but the lowest bit set. Alternating full and empty slices plus one make a carry that stops after one slice boundary. Two top-bit-only operands raise the carry-out with a zero sum. Random pairs cover mixed carries. A start pulse in the middle of an addition shows that the sequence is not restarted and the `done` timing does not change.

// File: rtl/madd_pkg.sv
package madd_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/padded_slice_adder.sv
module padded_slice_adder #(
  parameter int CHUNK_W = 32,
  parameter int PAD_W   = 16
) (
  input  logic [CHUNK_W-1:0] a_slice,
  input  logic [CHUNK_W-1:0] b_slice,
  input  logic               cin,
  output logic [CHUNK_W-1:0] sum_slice,
  output logic               cout
);

  localparam int DP_W = CHUNK_W + PAD_W;

  logic [DP_W-1:0] a_ext;
  logic [DP_W-1:0] b_ext;
  logic [DP_W-1:0] wide_sum;

  always_comb begin
    a_ext    = {{PAD_W{1'b0}}, a_slice};
    b_ext    = {{PAD_W{1'b1}}, b_slice};
    wide_sum = a_ext + b_ext + {{(DP_W-1){1'b0}}, cin};
  end

  // The ones pad stays intact unless the low part carries, which clears it.
  assign sum_slice = wide_sum[CHUNK_W-1:0];
  assign cout      = ~wide_sum[DP_W-1];

endmodule

// File: rtl/slice_mux.sv
module slice_mux #(
  parameter int TOTAL_W = 256,
  parameter int CHUNK_W = 32,
  parameter int CNT_W   = 3
) (
  input  logic [TOTAL_W-1:0] operand,
  input  logic [CNT_W-1:0]   sel,
  output logic [CHUNK_W-1:0] slice
);

  localparam int NCHUNK = TOTAL_W / CHUNK_W;

  logic [CHUNK_W-1:0] parts [NCHUNK];

  for (genvar g = 0; g < NCHUNK; g++) begin : g_part
    assign parts[g] = operand[g*CHUNK_W +: CHUNK_W];
  end

  assign slice = parts[sel];

endmodule

// File: rtl/slice_sequencer.sv
module slice_sequencer
  import madd_pkg::*;
#(
  parameter int NCHUNK = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             slice_cout,
  output logic             busy,
  output logic [CNT_W-1:0] idx,
  output logic             carry_in,
  output logic             wr_en,
  output logic             last_wr,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCHUNK - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             carry_q, carry_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    carry_d = carry_q;
    done_d  = 1'b0;
    wr_en   = 1'b0;
    last_wr = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
          carry_d = 1'b0;
        end
      end
      SEQ_RUN: begin
        wr_en   = 1'b1;
        carry_d = slice_cout;
        if (idx_q == LAST) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
          last_wr = 1'b1;
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      carry_q <= carry_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q == SEQ_RUN);
  assign idx      = idx_q;
  assign carry_in = carry_q;
  assign done     = done_q;

endmodule

// File: rtl/sum_store.sv
module sum_store #(
  parameter int TOTAL_W = 256,
  parameter int CHUNK_W = 32,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               last_wr,
  input  logic [CNT_W-1:0]   idx,
  input  logic [CHUNK_W-1:0] slice_sum,
  input  logic               slice_cout,
  output logic [TOTAL_W-1:0] sum,
  output logic               carry_out
);

  localparam int NCHUNK = TOTAL_W / CHUNK_W;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_slot
    logic [CHUNK_W-1:0] slot_q;
    logic               slot_en;

    assign slot_en = wr_en && (idx == CNT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slice_sum;
      end
    end

    assign sum[g*CHUNK_W +: CHUNK_W] = slot_q;
  end

  logic cout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cout_q <= 1'b0;
    end else if (last_wr) begin
      cout_q <= slice_cout;
    end
  end

  assign carry_out = cout_q;

endmodule

// File: rtl/chunked_wide_adder.sv
module chunked_wide_adder #(
  parameter int TOTAL_W = 256,
  parameter int CHUNK_W = 32,
  parameter int PAD_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TOTAL_W-1:0] op_a,
  input  logic [TOTAL_W-1:0] op_b,
  output logic [TOTAL_W-1:0] sum,
  output logic               carry_out,
  output logic               done
);

  localparam int NCHUNK = TOTAL_W / CHUNK_W;
  localparam int CNT_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

  logic               busy;
  logic [CNT_W-1:0]   slice_idx;
  logic               slice_cin;
  logic               wr_en;
  logic               last_wr;
  logic [CHUNK_W-1:0] a_slice;
  logic [CHUNK_W-1:0] b_slice;
  logic [CHUNK_W-1:0] slice_sum;
  logic               slice_cout;

  slice_sequencer #(.NCHUNK(NCHUNK), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .slice_cout (slice_cout),
    .busy       (busy),
    .idx        (slice_idx),
    .carry_in   (slice_cin),
    .wr_en      (wr_en),
    .last_wr    (last_wr),
    .done       (done)
  );

  slice_mux #(.TOTAL_W(TOTAL_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_mux_a (
    .operand (op_a),
    .sel     (slice_idx),
    .slice   (a_slice)
  );

  slice_mux #(.TOTAL_W(TOTAL_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_mux_b (
    .operand (op_b),
    .sel     (slice_idx),
    .slice   (b_slice)
  );

  padded_slice_adder #(.CHUNK_W(CHUNK_W), .PAD_W(PAD_W)) u_add (
    .a_slice   (a_slice),
    .b_slice   (b_slice),
    .cin       (slice_cin),
    .sum_slice (slice_sum),
    .cout      (slice_cout)
  );

  sum_store #(.TOTAL_W(TOTAL_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .last_wr    (last_wr),
    .idx        (slice_idx),
    .slice_sum  (slice_sum),
    .slice_cout (slice_cout),
    .sum        (sum),
    .carry_out  (carry_out)
  );

endmodule

// File: rtl/chunked_wide_adder_check.sv
module chunked_wide_adder_check #(
  parameter int NCHUNK = 8,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [CNT_W-1:0] idx,
  input logic             carry_in,
  input logic             done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCHUNK - 1);

  // R1: an accepted start enters the run at slice 0
  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && idx == '0));

  // R4: slice 0 always sees a zero carry-in
  a_r4_first_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> !carry_in);

  // R5: a running addition advances one slice per cycle, start or not
  a_r5_steady_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + CNT_W'(1)));

  // R1: done follows the cycle in which the last slice was in flight
  a_r1_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(idx) == LAST));

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind chunked_wide_adder chunked_wide_adder_check #(
  .NCHUNK (NCHUNK),
  .CNT_W  (CNT_W)
) u_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .idx      (slice_idx),
  .carry_in (slice_cin),
  .done     (done)
);

// File: tb/sim_chunked_wide_adder.sv
module sim_chunked_wide_adder;

  localparam int BW = 256;
  localparam int BN = 8;
  localparam int SW = 6;
  localparam int SN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          st_big = 1'b0;
  logic [BW-1:0] a_big = '0, b_big = '0;
  logic [BW-1:0] s_big;
  logic          c_big, d_big;

  logic          st_sm = 1'b0;
  logic [SW-1:0] a_sm = '0, b_sm = '0;
  logic [SW-1:0] s_sm;
  logic          c_sm, d_sm;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  chunked_wide_adder u0 (
    .clk(clk), .rst_n(rst_n), .start(st_big), .op_a(a_big), .op_b(b_big),
    .sum(s_big), .carry_out(c_big), .done(d_big)
  );

  chunked_wide_adder #(.TOTAL_W(SW), .CHUNK_W(2), .PAD_W(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(st_sm), .op_a(a_sm), .op_b(b_sm),
    .sum(s_sm), .carry_out(c_sm), .done(d_sm)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [BW:0] act, input logic [BW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // poke: pulse start again in the middle of the run
  task automatic run_big(input logic [BW-1:0] a, input logic [BW-1:0] b,
                         input bit poke, input string name);
    logic [BW:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    a_big = a; b_big = b; st_big = 1'b1;
    @(negedge clk);
    st_big = 1'b0;
    for (int i = 1; i < BN; i++) begin
      if (poke && i == 3) st_big = 1'b1;
      @(negedge clk);
      st_big = 1'b0;
      if (d_big) chk(1'b0, {"R5 early done ", name}, 1, 0);
    end
    @(negedge clk);
    chk(d_big == 1'b1, {"R1 done timing ", name}, d_big, 1);
    chk(s_big == exp[BW-1:0], {"R2 sum ", name}, s_big, exp[BW-1:0]);
    chk(c_big == exp[BW], {"R3 carry_out ", name}, c_big, exp[BW]);
    @(negedge clk);
    chk(d_big == 1'b0, {"R7 done width ", name}, d_big, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [BW-1:0] ones, alt, top, ra, rb;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(d_big == 1'b0, "R6 done in reset", d_big, 0);
    chk(s_big == '0, "R6 sum in reset", s_big, 0);
    chk(c_big == 1'b0, "R6 carry_out in reset", c_big, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(d_big == 1'b0 && s_big == '0, "R6 state after release", d_big, 0);
    // R7: no done while idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (d_big || d_sm) chk(1'b0, "R7 spurious done", 1, 0);
    end
    checks++;

    ones = '1;
    for (int k = 0; k < BN; k++) alt[k*32 +: 32] = (k % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
    top = '0; top[BW-1] = 1'b1;

    run_big('0, '0, 1'b0, "zero");
    run_big(ones, BW'(1), 1'b0, "R4 ripple all slices");
    run_big(ones, ones, 1'b0, "R4 all ones");
    run_big(alt, BW'(1), 1'b0, "R4 carry stops");
    run_big(top, top, 1'b0, "carry only");
    run_big(BW'(1), ones, 1'b1, "R5 start while busy");
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < BN; k++) begin
        ra[k*32 +: 32] = $urandom();
        rb[k*32 +: 32] = $urandom();
      end
      run_big(ra, rb, r[0], "random");
    end

    // R8: exhaustive sweep of the reduced configuration
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        logic [SW:0] e;
        e = {1'b0, SW'(x)} + {1'b0, SW'(y)};
        @(negedge clk);
        a_sm = SW'(x); b_sm = SW'(y); st_sm = 1'b1;
        @(negedge clk);
        st_sm = 1'b0;
        repeat (SN) @(negedge clk);
        chk(d_sm && {c_sm, s_sm} == e, "R8 reduced sweep",
            {d_sm, c_sm, s_sm}, {1'b1, e});
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule